// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a minimal 64-bit processor. Each instruction finishes in one clock cycle. It executes a small load/store subset:

- the register-to-register operations add, subtract, bitwise AND and bitwise OR;
- a doubleword load and a doubleword store, each addressed as a base register plus a signed offset;
- a conditional branch taken when a register holds zero;
- an unconditional PC-relative branch.

Instruction memory and data memory live inside the block. While reset is held, a simple preload port fills them. The core then runs from address 0.

The ALU selector comes from two levels of decode. The main decoder reduces each instruction to a 2-bit ALU class (add for memory access, pass operand B for the zero-test branch, opcode-driven for register operations). A small second decoder turns that class, together with the 11-bit opcode, into the 4-bit selector the ALU consumes.

The fetch, register read, ALU, memory and write-back paths are all combinational. Register file, data memory and PC update together on the rising edge. A peek port reads any register without disturbing execution, so results can be observed.

Top module: `lsr_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and every register to zero, and blocks all register and data-memory writes by the core while it is held.
- R2: Opcodes 10001011000, 11001011000, 10001010000 and 10101010000 in bits 31:21 write Rn+Rm, Rn-Rm, Rn AND Rm and Rn OR Rm into Rd. Rd is bits 4:0, Rn is bits 9:5 and Rm is bits 20:16.
- R3: Register 31 always reads as zero, and any write aimed at it is discarded.
- R4: Opcode 11111000010 loads into register bits 4:0 the data-memory doubleword at the address Rn + sign-extended bits 20:12. The doubleword is indexed by address bits above bit 2, wrapping modulo the memory depth.
- R5: Opcode 11111000000 stores the register named by bits 4:0 to the address formed as in R4, and writes no register.
- R6: When bits 31:24 are 10110100, the register named by bits 4:0 is passed through the ALU. If it is zero, the next PC is PC + (sign-extended bits 23:5 shifted left by 2); otherwise it is PC+4.
- R7: When bits 31:26 are 000101, the next PC is PC + (sign-extended bits 25:0 shifted left by 2).
- R8: Register operations, loads and stores advance the PC by 4, with one instruction per clock.
- R9: Any other encoding writes no register and no memory, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 = data memory, 0 = instruction memory |
| ld_addr | input | LAW (8) | Preload word index |
| ld_wdata | input | 64 | Preload data; the instruction memory takes bits 31:0 |
| pc_o | output | 64 | Current program counter |
| peek_idx | input | 5 | Register index for observation |
| peek_val | output | 64 | Value of the register at peek_idx; index 31 reads zero |

## Verification
The bench targets several corner cases, each with a distinct failure signature:

- **Register 31 as a destination.** Random register operations and a directed add aim at register 31. A core that let the write land would show a nonzero value there.
- **Negative memory offsets.** A negative load offset and a negative store offset from a nonzero base would hit the wrong doubleword if the offset were zero-extended or the index taken from the wrong address bits.
- **Zero-test branch.** A countdown loop exercises the branch both not taken and taken. A backward unconditional jump would trap or skip wrongly if its offset were not sign-extended or not scaled by four.
- **Unknown encodings.** An all-ones encoding and random encodings with an unused opcode must leave registers and memory untouched. A decoder that defaulted to an add would corrupt them.
- **Reset after activity.** Reset is applied after a run has left the register file full of random data, and every register and the PC must read zero.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int XLEN    = 64;
    localparam int ILEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX_W  = $clog2(NREGS);

    // ALU class from the main decoder
    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_PASSB = 2'b01,
        AOP_RTYPE = 2'b10
    } aluop_e;

    // selector driving the ALU
    typedef enum logic [3:0] {
        SEL_AND   = 4'b0000,
        SEL_OR    = 4'b0001,
        SEL_ADD   = 4'b0010,
        SEL_SUB   = 4'b0110,
        SEL_PASSB = 4'b0111,
        SEL_NOR   = 4'b1100
    } alusel_e;

    localparam logic [10:0] OPC_ADD  = 11'b10001011000;
    localparam logic [10:0] OPC_SUB  = 11'b11001011000;
    localparam logic [10:0] OPC_AND  = 11'b10001010000;
    localparam logic [10:0] OPC_ORR  = 11'b10101010000;
    localparam logic [10:0] OPC_LDUR = 11'b11111000010;
    localparam logic [10:0] OPC_STUR = 11'b11111000000;
    localparam logic [7:0]  OPC_CBZ  = 8'b10110100;
    localparam logic [5:0]  OPC_B    = 6'b000101;

    typedef struct packed {
        logic   rt_as_src2;   // second read index from bits 4:0
        logic   imm_src;      // ALU operand B is the 9-bit offset
        logic   mem_to_reg;   // write-back from data memory
        logic   reg_we;
        logic   mem_re;
        logic   mem_we;
        logic   cond_br;      // zero-test branch
        logic   uncond_br;
        aluop_e aluop;
    } ctrl_t;

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
    import lsr_pkg::*;
(
    input  logic [10:0] opc,
    output ctrl_t       ctrl
);

    logic is_rtype;

    always_comb begin
        is_rtype = (opc == OPC_ADD) || (opc == OPC_SUB) ||
                   (opc == OPC_AND) || (opc == OPC_ORR);
        ctrl = '0;
        if (is_rtype) begin
            ctrl.reg_we = 1'b1;
            ctrl.aluop  = AOP_RTYPE;
        end else if (opc == OPC_LDUR) begin
            ctrl.imm_src    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
            ctrl.reg_we     = 1'b1;
            ctrl.mem_re     = 1'b1;
            ctrl.aluop      = AOP_ADD;
        end else if (opc == OPC_STUR) begin
            ctrl.rt_as_src2 = 1'b1;
            ctrl.imm_src    = 1'b1;
            ctrl.mem_we     = 1'b1;
            ctrl.aluop      = AOP_ADD;
        end else if (opc[10:3] == OPC_CBZ) begin
            ctrl.rt_as_src2 = 1'b1;
            ctrl.cond_br    = 1'b1;
            ctrl.aluop      = AOP_PASSB;
        end else if (opc[10:5] == OPC_B) begin
            ctrl.uncond_br  = 1'b1;
            ctrl.aluop      = AOP_ADD;
        end
    end

endmodule

// File: rtl/lsr_alu_ctl.sv
module lsr_alu_ctl
    import lsr_pkg::*;
(
    input  aluop_e      aluop,
    input  logic [10:0] opc,
    output alusel_e     sel
);

    always_comb begin
        case (aluop)
            AOP_ADD:   sel = SEL_ADD;
            AOP_PASSB: sel = SEL_PASSB;
            AOP_RTYPE: begin
                case (opc)
                    OPC_ADD: sel = SEL_ADD;
                    OPC_SUB: sel = SEL_SUB;
                    OPC_AND: sel = SEL_AND;
                    OPC_ORR: sel = SEL_OR;
                    default: sel = SEL_ADD;
                endcase
            end
            default:   sel = SEL_ADD;
        endcase
    end

endmodule

// File: rtl/lsr_alu.sv
module lsr_alu
    import lsr_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alusel_e      sel,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (sel)
            SEL_AND:   y = a & b;
            SEL_OR:    y = a | b;
            SEL_ADD:   y = a + b;
            SEL_SUB:   y = a - b;
            SEL_PASSB: y = b;
            SEL_NOR:   y = ~(a | b);
            default:   y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/lsr_regfile.sv
module lsr_regfile
    import lsr_pkg::*;
#(
    parameter  int W  = XLEN,
    parameter  int N  = NREGS,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_p,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_p
);

    localparam logic [AW-1:0] ZREG = AW'(N - 1);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != ZREG)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a = (ra_a == ZREG) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == ZREG) ? '0 : regs_q[ra_b];
    assign rd_p = (ra_p == ZREG) ? '0 : regs_q[ra_p];

endmodule

// File: rtl/lsr_ram.sv
module lsr_ram #(
    parameter  int WIDTH = 32,
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/lsr_core.sv
module lsr_core
    import lsr_pkg::*;
#(
    parameter  int IMEM_WORDS = 256,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS),
    localparam int LAW        = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic              ld_dmem,
    input  logic [LAW-1:0]    ld_addr,
    input  logic [XLEN-1:0]   ld_wdata,
    output logic [XLEN-1:0]   pc_o,
    input  logic [RIDX_W-1:0] peek_idx,
    output logic [XLEN-1:0]   peek_val
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [ILEN-1:0]   instr;
    ctrl_t             ctrl;
    alusel_e           alu_sel;
    logic [RIDX_W-1:0] rn_idx, rm_idx, rt_idx, src2_idx;
    logic [XLEN-1:0]   rn_val, src2_val;
    logic [XLEN-1:0]   off_mem, off_cb, off_br, br_delta;
    logic [XLEN-1:0]   alu_b, alu_y, dmem_rdata, wb_data;
    logic              alu_zero, take_br;
    logic              imem_we, dmem_we, reg_we;
    logic [DAW-1:0]    dmem_waddr;
    logic [XLEN-1:0]   dmem_wdata;

    // instruction fetch
    assign imem_we = ld_we && !ld_dmem;

    lsr_ram #(.WIDTH(ILEN), .DEPTH(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_wdata[ILEN-1:0]),
        .raddr (st_q.pc[2 +: IAW]),
        .rdata (instr)
    );

    // decode
    lsr_decode u_dec (
        .opc  (instr[31:21]),
        .ctrl (ctrl)
    );

    lsr_alu_ctl u_actl (
        .aluop (ctrl.aluop),
        .opc   (instr[31:21]),
        .sel   (alu_sel)
    );

    assign rn_idx   = instr[9:5];
    assign rm_idx   = instr[20:16];
    assign rt_idx   = instr[4:0];
    assign src2_idx = ctrl.rt_as_src2 ? rt_idx : rm_idx;

    // immediates
    assign off_mem = XLEN'($signed(instr[20:12]));
    assign off_cb  = XLEN'($signed(instr[23:5]));
    assign off_br  = XLEN'($signed(instr[25:0]));

    assign reg_we  = ctrl.reg_we && !rst;

    lsr_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (rt_idx),
        .wdata (wb_data),
        .ra_a  (rn_idx),
        .ra_b  (src2_idx),
        .ra_p  (peek_idx),
        .rd_a  (rn_val),
        .rd_b  (src2_val),
        .rd_p  (peek_val)
    );

    // execute
    assign alu_b = ctrl.imm_src ? off_mem : src2_val;

    lsr_alu u_alu (
        .a    (rn_val),
        .b    (alu_b),
        .sel  (alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: preload port has priority, core writes blocked in reset
    always_comb begin
        dmem_we    = 1'b0;
        dmem_waddr = alu_y[3 +: DAW];
        dmem_wdata = src2_val;
        if (ld_we && ld_dmem) begin
            dmem_we    = 1'b1;
            dmem_waddr = ld_addr[DAW-1:0];
            dmem_wdata = ld_wdata;
        end else if (ctrl.mem_we && !rst) begin
            dmem_we    = 1'b1;
        end
    end

    lsr_ram #(.WIDTH(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_y[3 +: DAW]),
        .rdata (dmem_rdata)
    );

    assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

    // next PC
    always_comb begin
        take_br  = ctrl.uncond_br || (ctrl.cond_br && alu_zero);
        br_delta = (ctrl.uncond_br ? off_br : off_cb) << 2;
        st_d     = st_q;
        st_d.pc  = take_br ? (st_q.pc + br_delta) : (st_q.pc + XLEN'(4));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

    logic unused_bits;
    assign unused_bits = ^{st_q.pc[1:0], st_q.pc[XLEN-1:2+IAW],
                           alu_y[2:0], alu_y[XLEN-1:3+DAW], ctrl.mem_re};

endmodule

// File: rtl/lsr_core_chk.sv
module lsr_core_chk
    import lsr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [ILEN-1:0] instr,
    input ctrl_t           ctrl,
    input alusel_e         sel,
    input logic [XLEN-1:0] rn_val,
    input logic [XLEN-1:0] src2_val,
    input logic [XLEN-1:0] alu_y,
    input logic            alu_zero
);

    logic [XLEN-1:0] ck_off9, ck_cb, ck_br;
    logic            rst_seen_q = 1'b0;

    assign ck_off9 = {{55{instr[20]}}, instr[20:12]};
    assign ck_cb   = {{43{instr[23]}}, instr[23:5], 2'b00};
    assign ck_br   = {{36{instr[25]}}, instr[25:0], 2'b00};

    always @(posedge clk) rst_seen_q <= rst;

    // R1: PC is zero after any reset edge
    always @(negedge clk) begin
        if (rst_seen_q) begin
            a_r1_pc_reset: assert (pc == '0);
        end
    end

    a_r8_pc_seq: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.uncond_br || (ctrl.cond_br && alu_zero)) |=> pc == $past(pc) + 64'd4);

    a_r7_uncond: assert property (@(posedge clk) disable iff (rst)
        ctrl.uncond_br |=> pc == $past(pc) + $past(ck_br));

    a_r6_cbz_taken: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cond_br && alu_zero) |=> pc == $past(pc) + $past(ck_cb));

    a_r6_pass_b: assert property (@(posedge clk) disable iff (rst)
        ctrl.cond_br |-> (sel == SEL_PASSB) && (alu_y == src2_val));

    a_r4_addr: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mem_re || ctrl.mem_we) |-> (sel == SEL_ADD) && (alu_y == rn_val + ck_off9));

    a_r5_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_we |-> !ctrl.reg_we);

    a_r3_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (instr[9:5] == 5'd31) |-> rn_val == '0);

    a_r2_sel_range: assert property (@(posedge clk) disable iff (rst)
        (ctrl.aluop == AOP_RTYPE) |->
            (sel == SEL_ADD) || (sel == SEL_SUB) || (sel == SEL_AND) || (sel == SEL_OR));

endmodule

bind lsr_core lsr_core_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .pc       (st_q.pc),
    .instr    (instr),
    .ctrl     (ctrl),
    .sel      (alu_sel),
    .rn_val   (rn_val),
    .src2_val (src2_val),
    .alu_y    (alu_y),
    .alu_zero (alu_zero)
);

// File: tb/lsr_core_tb_top.sv
`timescale 1ns/1ps
module lsr_core_tb_top;

    localparam int IW  = 256;
    localparam int DW  = 64;
    localparam int LAW = 8;
    localparam logic [10:0] O_ADD  = 11'b10001011000;
    localparam logic [10:0] O_SUB  = 11'b11001011000;
    localparam logic [10:0] O_AND  = 11'b10001010000;
    localparam logic [10:0] O_ORR  = 11'b10101010000;
    localparam logic [10:0] O_LDUR = 11'b11111000010;
    localparam logic [10:0] O_STUR = 11'b11111000000;
    localparam logic [31:0] HALT   = {6'b000101, 26'd0};

    logic           clk = 1'b0;
    logic           rst;
    logic           ld_we, ld_dmem;
    logic [LAW-1:0] ld_addr;
    logic [63:0]    ld_wdata;
    logic [63:0]    pc_o;
    logic [4:0]     peek_idx;
    logic [63:0]    peek_val;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] ref_imem [IW];
    logic [63:0] ref_mem  [DW];
    logic [63:0] ref_regs [32];
    logic [63:0] ref_pc;

    always #5 clk = ~clk;

    lsr_core dut_i (
        .clk      (clk),
        .rst      (rst),
        .ld_we    (ld_we),
        .ld_dmem  (ld_dmem),
        .ld_addr  (ld_addr),
        .ld_wdata (ld_wdata),
        .pc_o     (pc_o),
        .peek_idx (peek_idx),
        .peek_val (peek_val)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic logic [63:0] sx(input logic [25:0] f, input int n);
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < 64; k++) r[k] = (k < n) ? f[k] : f[n-1];
        return r;
    endfunction

    function automatic logic [31:0] enc_r(input logic [10:0] op, input int rd, input int rn, input int rm);
        return {op, 5'(rm), 6'd0, 5'(rn), 5'(rd)};
    endfunction
    function automatic logic [31:0] enc_d(input logic [10:0] op, input int rt, input int rn, input logic [8:0] imm);
        return {op, imm, 2'b00, 5'(rn), 5'(rt)};
    endfunction
    function automatic logic [31:0] enc_cb(input int rt, input logic [18:0] imm);
        return {8'b10110100, imm, 5'(rt)};
    endfunction
    function automatic logic [31:0] enc_b(input logic [25:0] imm);
        return {6'b000101, imm};
    endfunction

    function automatic logic [63:0] rreg(input int i);
        return (i == 31) ? 64'd0 : ref_regs[i];
    endfunction

    // reference model built from R2..R9
    task automatic ref_step(output string tag);
        logic [31:0] w;
        logic [63:0] nxt, addr, res;
        int rn, rm, rt;
        logic wr;
        w   = ref_imem[ref_pc[2 +: 8]];
        rn  = int'(w[9:5]);
        rm  = int'(w[20:16]);
        rt  = int'(w[4:0]);
        nxt = ref_pc + 64'd4;
        wr  = 1'b0;
        res = '0;
        addr = rreg(rn) + sx(26'(w[20:12]), 9);
        tag = "R8";
        if (w[31:21] == O_ADD)      begin res = rreg(rn) + rreg(rm); wr = 1'b1; end
        else if (w[31:21] == O_SUB) begin res = rreg(rn) - rreg(rm); wr = 1'b1; end
        else if (w[31:21] == O_AND) begin res = rreg(rn) & rreg(rm); wr = 1'b1; end
        else if (w[31:21] == O_ORR) begin res = rreg(rn) | rreg(rm); wr = 1'b1; end
        else if (w[31:21] == O_LDUR) begin res = ref_mem[addr[8:3]]; wr = 1'b1; end
        else if (w[31:21] == O_STUR) begin ref_mem[addr[8:3]] = rreg(rt); end
        else if (w[31:24] == 8'b10110100) begin
            tag = "R6";
            if (rreg(rt) == 64'd0) nxt = ref_pc + (sx(26'(w[23:5]), 19) << 2);
        end else if (w[31:26] == 6'b000101) begin
            tag = "R7";
            nxt = ref_pc + (sx(w[25:0], 26) << 2);
        end else begin
            tag = "R9";
        end
        if (wr && rt != 31) ref_regs[rt] = res;
        ref_pc = nxt;
    endtask

    task automatic put_i(input int idx, input logic [31:0] w);
        ld_we = 1'b1; ld_dmem = 1'b0; ld_addr = LAW'(idx); ld_wdata = {32'd0, w};
        ref_imem[idx] = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic put_d(input int idx, input logic [63:0] v);
        ld_we = 1'b1; ld_dmem = 1'b1; ld_addr = LAW'(idx); ld_wdata = v;
        ref_mem[idx] = v;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic ref_reset();
        ref_pc = '0;
        for (int i = 0; i < 32; i++) ref_regs[i] = '0;
    endtask

    task automatic run(input int n);
        string tag;
        repeat (n) begin
            ref_step(tag);
            @(negedge clk);
            chk(tag, pc_o, ref_pc);
        end
    endtask

    task automatic peek(input int i, output logic [63:0] v);
        peek_idx = 5'(i);
        #1;
        v = peek_val;
    endtask

    task automatic check_regs();
        logic [63:0] v;
        for (int i = 0; i < 31; i++) begin
            peek(i, v);
            chk("R2", v, ref_regs[i]);
        end
        peek(31, v);
        chk("R3", v, 64'd0);
    endtask

    function automatic logic [31:0] rand_instr(input int slot);
        int r;
        logic [10:0] op;
        r = int'($urandom % 10);
        case ($urandom % 4)
            0: op = O_ADD;
            1: op = O_SUB;
            2: op = O_AND;
            default: op = O_ORR;
        endcase
        if (r < 6) return enc_r(op, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32));
        if (r == 6) return enc_d(O_STUR, int'($urandom % 32), int'($urandom % 32), 9'($urandom));
        if (r == 7) return enc_d(O_LDUR, int'($urandom % 32), int'($urandom % 32), 9'($urandom));
        if (r == 8) return (slot % 2 == 0) ? 32'hFFFF_FFFF : {11'd0, 21'($urandom)};
        return enc_cb(int'($urandom % 32), 19'(1 + ($urandom % 2)));
    endfunction

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R8: watchdog expired actual=%h expected=halt", pc_o);
        summary();
        $finish;
    end

    initial begin
        logic [63:0] v;
        rst = 1'b1; ld_we = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_wdata = '0; peek_idx = '0;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);

        // test 1: random data, register fill, random instruction stream
        for (int i = 0; i < DW; i++) put_d(i, {$urandom, $urandom});
        for (int i = 0; i < 32; i++) put_i(i, enc_d(O_LDUR, i, 31, 9'(i * 8)));
        for (int j = 0; j < 200; j++) put_i(32 + j, rand_instr(j));
        for (int k = 232; k < IW; k++) put_i(k, HALT);
        ref_reset();
        chk("R1", pc_o, 64'd0);
        rst = 1'b0;
        run(245);
        check_regs();

        // reset after activity
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", pc_o, 64'd0);
        for (int i = 0; i < 32; i++) begin
            peek(i, v);
            chk("R1", v, 64'd0);
        end

        // test 2: directed offsets, loop, branches, unknown encoding
        put_d(0, 64'd3);
        put_d(1, 64'd1);
        put_d(2, 64'd64);
        put_d(7, 64'h1234_5678_9ABC_DEF0);
        put_i(0,  enc_d(O_LDUR, 1, 31, 9'd0));
        put_i(1,  enc_d(O_LDUR, 2, 31, 9'd8));
        put_i(2,  enc_d(O_LDUR, 3, 31, 9'd16));
        put_i(3,  enc_d(O_LDUR, 4, 3, 9'h1F8));
        put_i(4,  enc_d(O_STUR, 4, 3, 9'h1F0));
        put_i(5,  enc_d(O_LDUR, 5, 31, 9'd48));
        put_i(6,  enc_cb(2, 19'd5));
        put_i(7,  enc_r(O_SUB, 1, 1, 2));
        put_i(8,  enc_cb(1, 19'd2));
        put_i(9,  enc_b(26'h3FF_FFFE));
        put_i(10, enc_b(26'd2));
        put_i(11, enc_r(O_ADD, 6, 2, 2));
        put_i(12, 32'hFFFF_FFFF);
        put_i(13, enc_r(O_ADD, 31, 2, 2));
        put_i(14, enc_r(O_ORR, 7, 31, 2));
        put_i(15, enc_r(O_AND, 8, 3, 5));
        for (int k = 16; k < IW; k++) put_i(k, HALT);
        ref_reset();
        rst = 1'b0;
        run(40);
        peek(4, v); chk("R4", v, 64'h1234_5678_9ABC_DEF0);
        peek(5, v); chk("R5", v, 64'h1234_5678_9ABC_DEF0);
        peek(1, v); chk("R6", v, 64'd0);
        peek(6, v); chk("R7", v, 64'd0);
        peek(7, v); chk("R3", v, 64'd1);
        peek(8, v); chk("R2", v, 64'd64 & 64'h1234_5678_9ABC_DEF0);
        chk("R7", pc_o, 64'd64);
        check_regs();

        summary();
        $finish;
    end

endmodule